// File: doc/BRIEF.md
# Serial DAC update sequencer

This block is the host-side controller for a four-channel, double-buffered, serially loaded digital-to-analog converter. It takes one request at a time. Each request carries a 2-bit channel number, a 12-bit code, a mode flag, a commit flag and two timing settings. The block turns the request into the converter's chip-select, serial clock, serial data and two active-low load strobes. The first strobe (`dac_ldreg_n`) copies the shifted word into the addressed channel's input register. The second strobe (`dac_lddac_n`) moves all input registers to the outputs at the same moment.

In buffered mode the host writes any number of channels with the commit flag clear. Each of these words gets only its own register-load strobe. On the last word it sets the commit flag, and the block then issues one output-load pulse that updates every channel together. In immediate mode the output-load line is held low, so each channel's output follows its register-load strobe directly.

The edges are ordered so that the converter can never see a false shift clock, and no register is loaded while the address bits are still in motion. Chip-select only changes while the serial clock is high. The register-load strobe is only issued after chip-select has gone back high.

Top module: `qdac_update_seq`

## Requirements
- R1: During and after synchronous reset, with no request taken, the outputs are `dac_cs_n`=1, `dac_sclk`=1, `dac_sdata`=0, `dac_ldreg_n`=1, `dac_lddac_n`=1, `busy`=0 and `done`=0.
- R2: Each request sends a 14-bit word, most significant bit first: `req_chan[1:0]` followed by `req_value[11:0]`. A new bit is presented only when `dac_sclk` falls, except the first bit, which is presented when `dac_cs_n` falls. Each bit is held unchanged while `dac_sclk` is high.
- R3: Every low half and every high half of the serial clock lasts H system clocks, where H = `cfg_half_div` (a value of 0 counts as 1). `dac_cs_n` falls with `dac_sclk` high, H clocks before the first falling clock edge. `dac_sclk` is never low while `dac_cs_n` is high.
- R4: After the 14th rising edge of `dac_sclk`, `dac_cs_n` stays low for the rest of that high half. It then rises while `dac_sclk` is still high.
- R5: Every word gets exactly one `dac_ldreg_n` low pulse. The pulse starts in the cycle in which `dac_cs_n` rises and lasts S clocks, where S = max(`cfg_strobe_len`, 2*H).
- R6: In buffered mode (`req_immediate`=0) with `req_commit`=1, `dac_lddac_n` pulses low for S clocks, starting in the cycle in which `dac_ldreg_n` returns high. With `req_commit`=0, `dac_lddac_n` stays high for the whole request.
- R7: In immediate mode (`req_immediate`=1), `dac_lddac_n` is low from the first cycle after acceptance. It stays low through the following idle time until a buffered request is accepted. `req_commit` has no effect in this mode.
- R8: A request is taken on a clock edge where `req_valid`=1 and `busy`=0. `busy` is 1 from the next cycle until the last strobe cycle. `done` is 1 for exactly the one cycle that follows, with `busy`=0. A `req_valid` raised while `busy`=1 is ignored.
- R9: Channel, value, mode, commit and both timing settings are sampled only at acceptance. Changes to them while `busy`=1 do not alter the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_chan | input | 2 | Channel address sent ahead of the code |
| req_value | input | 12 | Code for the channel |
| req_immediate | input | 1 | 1 = immediate mode, 0 = buffered mode |
| req_commit | input | 1 | Buffered mode: update all outputs after this word |
| cfg_half_div | input | 8 | System clocks per serial half period (0 treated as 1) |
| cfg_strobe_len | input | 10 | Requested strobe length in system clocks |
| dac_cs_n | output | 1 | Converter chip-select, active low |
| dac_sclk | output | 1 | Serial shift clock, idles high |
| dac_sdata | output | 1 | Serial data |
| dac_ldreg_n | output | 1 | Input-register load strobe, active low |
| dac_lddac_n | output | 1 | Output-register load strobe, active low |
| busy | output | 1 | Transfer or strobe in progress |
| done | output | 1 | One-cycle pulse when a request completes |

## Verification
The main function is driven with several kinds of request:
- Buffered words without commit and with commit. These show whether the output-load pulse appears only when it is asked for.
- Immediate-mode words, including one with the commit flag set. These show that the output-load line stays low and that the flag is ignored.
- A change from immediate back to buffered mode. This shows that the idle level of the output-load line follows the last accepted mode.
- Divider values of 0, 1, 2 and 3. These separate the zero-as-one rule and distinguish the half-period count from the full period.
- Strobe lengths below and above twice the half period. These show which of the two bounds sets the pulse width.
- Codes such as all-ones, a single set bit and alternating bits, on different channels. These expose bit-order and address-order faults.
- A request held up during a transfer, plus configuration inputs changed right after acceptance. These show whether anything is sampled outside the acceptance edge.

// File: rtl/qdac_seq_pkg.sv
`timescale 1ns/1ps
package qdac_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_LOW   = 3'd2,
    ST_HIGH  = 3'd3,
    ST_LDREG = 3'd4,
    ST_LDDAC = 3'd5
  } seq_state_t;

endpackage

// File: rtl/qdac_len_calc.sv
`timescale 1ns/1ps
// Turns the raw timing settings into effective phase lengths:
// the half period is at least 1, and a strobe is at least one full serial period.
module qdac_len_calc #(
  parameter int DIV_W = 8,
  parameter int STB_W = 10,
  parameter int TW    = 10
) (
  input  logic [DIV_W-1:0] half_raw,
  input  logic [STB_W-1:0] strobe_raw,
  output logic [TW-1:0]    half_eff,
  output logic [TW-1:0]    strobe_eff
);
  logic [TW-1:0] dbl;
  logic [TW-1:0] s_ext;

  always_comb begin
    half_eff   = (half_raw == '0) ? TW'(1) : TW'(half_raw);
    dbl        = half_eff << 1;
    s_ext      = TW'(strobe_raw);
    strobe_eff = (s_ext < dbl) ? dbl : s_ext;
  end
endmodule

// File: rtl/qdac_phase_timer.sv
`timescale 1ns/1ps
// Down-counter that measures one phase. It is loaded with the phase length;
// last is high in the final cycle of the phase.
module qdac_phase_timer #(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] len,
  output logic          last
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= len;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - TW'(1);
    end
  end

  assign last = (cnt_q == TW'(1));
endmodule

// File: rtl/qdac_word_shifter.sv
`timescale 1ns/1ps
// Parallel-in, serial-out register, MSB first. The msb flop drives the data pin directly.
module qdac_word_shifter #(
  parameter int WORD_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic              clear,
  input  logic [WORD_W-1:0] word,
  output logic              msb
);
  logic [WORD_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sr_q <= '0;
    end else if (load) begin
      sr_q <= word;
    end else if (shift) begin
      sr_q <= {sr_q[WORD_W-2:0], 1'b0};
    end
  end

  assign msb = sr_q[WORD_W-1];
endmodule

// File: rtl/qdac_update_seq.sv
`timescale 1ns/1ps
module qdac_update_seq
  import qdac_seq_pkg::*;
#(
  parameter int CH_W  = 2,
  parameter int VAL_W = 12,
  parameter int DIV_W = 8,
  parameter int STB_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [CH_W-1:0]  req_chan,
  input  logic [VAL_W-1:0] req_value,
  input  logic             req_immediate,
  input  logic             req_commit,
  input  logic [DIV_W-1:0] cfg_half_div,
  input  logic [STB_W-1:0] cfg_strobe_len,
  output logic             dac_cs_n,
  output logic             dac_sclk,
  output logic             dac_sdata,
  output logic             dac_ldreg_n,
  output logic             dac_lddac_n,
  output logic             busy,
  output logic             done
);
  localparam int WORD_W = CH_W + VAL_W;
  localparam int TW     = (DIV_W + 1 > STB_W) ? DIV_W + 1 : STB_W;
  localparam int BIT_W  = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  seq_state_t st_q, st_d;
  logic          accept;
  logic [TW-1:0] half_req, strobe_req, half_q, strobe_q;
  logic          imm_q, imm_d, commit_q;
  logic [BIT_W-1:0] bit_q;
  logic          tmr_load, tmr_last;
  logic [TW-1:0] tmr_len;
  logic          sh_load, sh_shift, sh_clear;

  qdac_len_calc #(.DIV_W(DIV_W), .STB_W(STB_W), .TW(TW)) u_len (
    .half_raw   (cfg_half_div),
    .strobe_raw (cfg_strobe_len),
    .half_eff   (half_req),
    .strobe_eff (strobe_req)
  );

  qdac_phase_timer #(.TW(TW)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .load (tmr_load),
    .len  (tmr_len),
    .last (tmr_last)
  );

  qdac_word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .load  (sh_load),
    .shift (sh_shift),
    .clear (sh_clear),
    .word  ({req_chan, req_value}),
    .msb   (dac_sdata)
  );

  // Phase sequencing.
  // The first bit is set up with cs_n. Each later bit is set up as sclk falls.
  // cs_n rises only at the end of a high half, and the strobes follow afterwards.
  always_comb begin
    st_d     = st_q;
    accept   = 1'b0;
    tmr_load = 1'b0;
    tmr_len  = half_q;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    sh_clear = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          st_d     = ST_LEAD;
          tmr_load = 1'b1;
          tmr_len  = half_req;
          sh_load  = 1'b1;
        end
      end
      ST_LEAD: begin
        if (tmr_last) begin
          st_d     = ST_LOW;
          tmr_load = 1'b1;
        end
      end
      ST_LOW: begin
        if (tmr_last) begin
          st_d     = ST_HIGH;
          tmr_load = 1'b1;
        end
      end
      ST_HIGH: begin
        if (tmr_last) begin
          tmr_load = 1'b1;
          if (bit_q == LAST_BIT) begin
            st_d     = ST_LDREG;
            tmr_len  = strobe_q;
            sh_clear = 1'b1;
          end else begin
            st_d     = ST_LOW;
            sh_shift = 1'b1;
          end
        end
      end
      ST_LDREG: begin
        if (tmr_last) begin
          if (!imm_q && commit_q) begin
            st_d     = ST_LDDAC;
            tmr_load = 1'b1;
            tmr_len  = strobe_q;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_LDDAC: begin
        if (tmr_last) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign imm_d = accept ? req_immediate : imm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      imm_q    <= 1'b0;
      commit_q <= 1'b0;
      half_q   <= TW'(1);
      strobe_q <= TW'(2);
      bit_q    <= '0;
    end else begin
      st_q  <= st_d;
      imm_q <= imm_d;
      if (accept) begin
        commit_q <= req_commit;
        half_q   <= half_req;
        strobe_q <= strobe_req;
        bit_q    <= '0;
      end else if (sh_shift) begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  // Pin flops are loaded from the next state so that each pin changes together with the state.
  always_ff @(posedge clk) begin
    if (rst) begin
      dac_cs_n    <= 1'b1;
      dac_sclk    <= 1'b1;
      dac_ldreg_n <= 1'b1;
      dac_lddac_n <= 1'b1;
      busy        <= 1'b0;
      done        <= 1'b0;
    end else begin
      dac_cs_n    <= !(st_d == ST_LEAD || st_d == ST_LOW || st_d == ST_HIGH);
      dac_sclk    <= (st_d != ST_LOW);
      dac_ldreg_n <= (st_d != ST_LDREG);
      dac_lddac_n <= !imm_d && (st_d != ST_LDDAC);
      busy        <= (st_d != ST_IDLE);
      done        <= (st_q != ST_IDLE) && (st_d == ST_IDLE);
    end
  end
endmodule

// File: rtl/qdac_update_seq_chk.sv
`timescale 1ns/1ps
module qdac_update_seq_chk (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic sclk,
  input logic sdata,
  input logic ldreg_n,
  input logic lddac_n,
  input logic busy,
  input logic done
);
  // R3: the shift clock only goes low inside a frame
  p_sclk_in_frame_r3: assert property (@(posedge clk) disable iff (rst)
    !sclk |-> !cs_n);

  // R4: chip-select rises only while the clock is, and was, high
  p_cs_rise_high_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (sclk && $past(sclk)));

  // R2: data holds across a high half inside a frame
  p_data_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk) && !cs_n && !$past(cs_n)) |-> $stable(sdata));

  // R5: register load only with the frame closed and the clock high
  p_ldreg_closed_r5: assert property (@(posedge clk) disable iff (rst)
    !ldreg_n |-> (cs_n && sclk && busy));

  // R6: output load inside a request starts as the register load ends
  p_lddac_after_ldreg_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(lddac_n) && $past(busy)) |-> $rose(ldreg_n));

  // R8: done is a single-cycle pulse, idle, right after busy
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_after_busy_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
endmodule

bind qdac_update_seq qdac_update_seq_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .cs_n    (dac_cs_n),
  .sclk    (dac_sclk),
  .sdata   (dac_sdata),
  .ldreg_n (dac_ldreg_n),
  .lddac_n (dac_lddac_n),
  .busy    (busy),
  .done    (done)
);

// File: tb/qdac_update_seq_tb.sv
`timescale 1ns/1ps
module qdac_update_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_chan = '0;
  logic [11:0] req_value = '0;
  logic        req_immediate = 1'b0;
  logic        req_commit = 1'b0;
  logic [7:0]  cfg_half_div = 8'd1;
  logic [9:0]  cfg_strobe_len = 10'd0;
  logic dac_cs_n, dac_sclk, dac_sdata, dac_ldreg_n, dac_lddac_n, busy, done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  qdac_update_seq u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_chan(req_chan),
    .req_value(req_value), .req_immediate(req_immediate), .req_commit(req_commit),
    .cfg_half_div(cfg_half_div), .cfg_strobe_len(cfg_strobe_len),
    .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk), .dac_sdata(dac_sdata),
    .dac_ldreg_n(dac_ldreg_n), .dac_lddac_n(dac_lddac_n), .busy(busy), .done(done)
  );

  // Reference model. Expected pin vector bits: {cs_n, sclk, sdata, ldreg_n, lddac_n, busy, done}
  logic [6:0] exp_q[$];
  logic [6:0] cur;
  bit         mode_imm = 1'b0;
  bit         started = 1'b0;

  task automatic gen_request(input logic [1:0] ch, input logic [11:0] val, input bit imm,
                             input bit cm, input int hraw, input int sraw);
    int h, s;
    logic [13:0] w;
    logic base;
    h = (hraw == 0) ? 1 : hraw;
    s = (sraw < 2*h) ? 2*h : sraw;
    w = {ch, val};
    base = !imm;
    repeat (h) exp_q.push_back({1'b0, 1'b1, w[13], 1'b1, base, 1'b1, 1'b0});
    for (int i = 0; i < 14; i++) begin
      repeat (h) exp_q.push_back({1'b0, 1'b0, w[13-i], 1'b1, base, 1'b1, 1'b0});
      repeat (h) exp_q.push_back({1'b0, 1'b1, w[13-i], 1'b1, base, 1'b1, 1'b0});
    end
    repeat (s) exp_q.push_back({1'b1, 1'b1, 1'b0, 1'b0, base, 1'b1, 1'b0});
    if (!imm && cm)
      repeat (s) exp_q.push_back({1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0});
    exp_q.push_back({1'b1, 1'b1, 1'b0, 1'b1, base, 1'b0, 1'b1});
  endtask

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      exp_q.delete();
      mode_imm = 1'b0;
      cur = 7'b1101100;
    end else begin
      if (!cur[1] && req_valid) begin
        mode_imm = req_immediate;
        gen_request(req_chan, req_value, req_immediate, req_commit,
                    int'(cfg_half_div), int'(cfg_strobe_len));
      end
      if (exp_q.size() > 0) cur = exp_q.pop_front();
      else cur = {1'b1, 1'b1, 1'b0, 1'b1, !mode_imm, 1'b0, 1'b0};
    end
  end

  task automatic field_chk(input logic act, input logic exp, input string tag, input string nm);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual=%b expected=%b", tag, nm, cyc, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !finished) begin
      checks++;
      if (rst) begin
        field_chk(dac_cs_n, cur[6], "R1", "cs_n");
        field_chk(dac_sclk, cur[5], "R1", "sclk");
        field_chk(dac_ldreg_n, cur[3], "R1", "ldreg_n");
        field_chk(dac_lddac_n, cur[2], "R1", "lddac_n");
        field_chk(busy, cur[1], "R1", "busy");
        field_chk(done, cur[0], "R1", "done");
      end else begin
        field_chk(dac_cs_n, cur[6], "R4", "cs_n");
        field_chk(dac_sclk, cur[5], "R3", "sclk");
        field_chk(dac_sdata, cur[4], "R2", "sdata");
        field_chk(dac_ldreg_n, cur[3], "R5", "ldreg_n");
        field_chk(dac_lddac_n, cur[2], mode_imm ? "R7" : "R6", "lddac_n");
        field_chk(busy, cur[1], "R8", "busy");
        field_chk(done, cur[0], "R8", "done");
      end
    end
  end

  // Pulse-length monitors: counted at the ports, read as before/after differences
  int mon_busy = 0, mon_ldreg = 0, mon_lddac = 0;
  always @(negedge clk) begin
    if (!rst && busy) begin
      mon_busy++;
      if (!dac_ldreg_n) mon_ldreg++;
      if (!dac_lddac_n) mon_lddac++;
    end
  end

  task automatic chk_int(input int act, input int exp, input string tag, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic run_req(input logic [1:0] ch, input logic [11:0] val, input bit imm,
                         input bit cm, input int hraw, input int sraw, input bit poke_busy);
    int h, s, b0, l0, d0, nb;
    h = (hraw == 0) ? 1 : hraw;
    s = (sraw < 2*h) ? 2*h : sraw;
    step();
    while (busy) step();
    b0 = mon_busy; l0 = mon_ldreg; d0 = mon_lddac;
    req_chan = ch; req_value = val; req_immediate = imm; req_commit = cm;
    cfg_half_div = 8'(hraw); cfg_strobe_len = 10'(sraw);
    req_valid = 1'b1;
    step();
    // R9: scramble every sampled input right after acceptance
    req_valid = 1'b0;
    req_chan = ~ch; req_value = ~val; req_immediate = !imm; req_commit = !cm;
    cfg_half_div = 8'd7; cfg_strobe_len = 10'd3;
    if (poke_busy) begin
      // R8: a request raised while busy is ignored
      repeat (6) step();
      req_valid = 1'b1;
      repeat (3) step();
      req_valid = 1'b0;
    end
    while (busy) step();
    nb = h + 28*h + s + ((!imm && cm) ? s : 0);
    chk_int(mon_busy - b0, nb, "R8", "busy cycles");
    chk_int(mon_ldreg - l0, s, "R5", "ldreg_n low cycles");
    if (imm) chk_int(mon_lddac - d0, nb, "R7", "lddac_n low cycles while busy");
    else chk_int(mon_lddac - d0, cm ? s : 0, "R6", "lddac_n low cycles");
    checks++;
    if (done !== 1'b1) begin
      errors++;
      $display("FAIL R8 done after request: actual=%b expected=1", done);
    end
    step();
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state at the ports
    checks++;
    if ({dac_cs_n, dac_sclk, dac_sdata, dac_ldreg_n, dac_lddac_n, busy, done} !== 7'b1101100) begin
      errors++;
      $display("FAIL R1 reset pins: actual=%b expected=1101100",
               {dac_cs_n, dac_sclk, dac_sdata, dac_ldreg_n, dac_lddac_n, busy, done});
    end
    @(negedge clk); rst = 1'b0;
    repeat (3) step();
    run_req(2'd0, 12'hA5C, 1'b0, 1'b0, 1, 0, 1'b0);   // R6 buffered, no commit
    run_req(2'd3, 12'h3FF, 1'b0, 1'b1, 2, 7, 1'b1);   // R6 commit, R8 busy poke, R9
    run_req(2'd2, 12'hFFF, 1'b0, 1'b1, 0, 1, 1'b0);   // R3 divider 0 treated as 1
    run_req(2'd1, 12'h001, 1'b1, 1'b0, 3, 3, 1'b0);   // R7 immediate
    run_req(2'd2, 12'h800, 1'b1, 1'b1, 1, 9, 1'b0);   // R7 commit ignored
    repeat (5) step();
    checks++;
    if (dac_lddac_n !== 1'b0) begin
      errors++;
      $display("FAIL R7 idle lddac_n after immediate: actual=%b expected=0", dac_lddac_n);
    end
    run_req(2'd1, 12'h555, 1'b0, 1'b1, 2, 2, 1'b0);   // R6 back to buffered
    repeat (5) step();
    checks++;
    if (dac_lddac_n !== 1'b1) begin
      errors++;
      $display("FAIL R6 idle lddac_n after buffered: actual=%b expected=1", dac_lddac_n);
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000 && !finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL R8 watchdog: actual=hung expected=idle");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule